// File: doc/BRIEF.md
# Message Register Doorbell Interrupt Unit

The unit provides eight 32-bit mailbox slots that one agent writes and another consumes. Each slot has its own interrupt line. Software on the sending side writes a slot. If that slot is armed, the write also latches a pending event, and the slot's interrupt line goes high unless the slot is masked. The receiving side reads the slot to take the message, and that read retires the event. The receiver can also retire events without reading the slot by writing ones to a status register.

Each slot contains a two-state machine with states IDLE and PEND:

- **ARM**: IDLE to PEND, on an armed write to the slot.
- **HOLD**: PEND to PEND, when PEND sees an armed write, or sees no clearing access.
- **RETIRE**: PEND to IDLE, on a read of the slot or a one written to the slot's status bit, when no armed write arrives in the same cycle.
- **IGNORE**: IDLE to IDLE, on every other access.

The arm bit is sampled at write time. A write made while the slot is disarmed is dropped for good. The mask bit only hides the line. The event itself is kept.

Top module: `msg_doorbell_unit`

## Requirements
- R1: Eight slots, each 32 bits wide, sit at byte offsets 0x00, 0x04, …, 0x1C (slot n at 4·n). A write stores the data. A read returns the stored data. All slots reset to zero.
- R2: A write to slot n while its arm bit is set makes the slot pending. irq[n] rises at the clock edge that performs the write, provided mask bit n is clear.
- R3: A read of slot n retires its pending event. irq[n] falls at the clock edge of the read.
- R4: Status register at offset 0x28: bit n reads as the pending flag of slot n. Writing a 1 to bit n retires that event. A 0 bit has no effect. Reading the status register has no side effect.
- R5: A write to a disarmed slot creates no event. Arming the slot afterwards does not recover it.
- R6: Mask register at offset 0x2C: bit n, when set, holds irq[n] low. The event stays pending. Clearing the bit brings the line back while the event is still pending.
- R7: Arm register A at offset 0x20 holds slots 0 to 3 in bits 31 down to 28 (bit 31 is slot 0). Arm register B at offset 0x24 holds slots 4 to 7 in the same layout. Both read back and reset to zero. The mask register also resets to zero.
- R8: Reset returns every slot to IDLE, clears all data, arm and mask bits, and drives irq to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 8 | One interrupt line per slot |

## Verification
The bench builds the unit with its defaults: a 32-bit data path and an 8-bit offset space. At these values both arm registers are live. The bench can therefore place the arm bit of slot 0 at bit 31 of register A and the arm bit of slot 7 at bit 28 of register B, and check each in the same run. With eight slots it can hold two events pending at once and retire one of them selectively, through status writes, through reads, and under a mask.

// File: rtl/msg_pkg.sv
package msg_pkg;
    localparam int NUM_SLOT  = 8;
    localparam int GROUP_SZ  = 4;
    localparam int WORD_ENA  = 8;
    localparam int WORD_ENB  = 9;
    localparam int WORD_STAT = 10;
    localparam int WORD_MASK = 11;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_PEND = 1'b1
    } slot_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MSG,
        SEL_ENA,
        SEL_ENB,
        SEL_STAT,
        SEL_MASK
    } reg_sel_e;
endpackage

// File: rtl/msg_bus_decode.sv
module msg_bus_decode
    import msg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          sel,
    output logic [2:0]        slot_idx
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;

    assign word     = bus_addr[ADDR_W-1:2];
    assign slot_idx = bus_addr[4:2];

    always_comb begin
        sel = SEL_NONE;
        if (bus_sel && bus_addr[1:0] == 2'b00) begin
            if (word < WORD_W'(NUM_SLOT))            sel = SEL_MSG;
            else if (word == WORD_W'(WORD_ENA))     sel = SEL_ENA;
            else if (word == WORD_W'(WORD_ENB))     sel = SEL_ENB;
            else if (word == WORD_W'(WORD_STAT))    sel = SEL_STAT;
            else if (word == WORD_W'(WORD_MASK))    sel = SEL_MASK;
            else                                    sel = SEL_NONE;
        end
    end
endmodule

// File: rtl/msg_slot.sv
module msg_slot
    import msg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic              clr_hit,
    input  logic              armed,
    input  logic              mask_nxt,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] msg,
    output logic              pend,
    output logic              irq
);
    slot_state_e state_q, state_d;
    logic        mask_q;
    logic        arm_wr;

    assign arm_wr = wr_hit && armed;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: if (arm_wr) state_d = SLOT_PEND;
            SLOT_PEND: if (!arm_wr && (rd_hit || clr_hit)) state_d = SLOT_IDLE;
            default:   state_d = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg    <= '0;
            irq    <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (wr_hit) msg <= wdata;
            irq    <= (state_d == SLOT_PEND) && !mask_nxt;
            mask_q <= mask_nxt;
        end
    end

    assign pend = (state_q == SLOT_PEND);

    p_armed_write_pends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> pend);
    p_disarmed_write_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && wr_hit && !armed) |=> !pend);
    p_read_retires_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && (rd_hit || clr_hit) && !arm_wr) |=> !pend);
    p_irq_follows_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (pend && !mask_q));
    p_data_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(msg));
endmodule

// File: rtl/msg_doorbell_unit.sv
module msg_doorbell_unit
    import msg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_SLOT-1:0] irq
);
    localparam int TOP_BIT = DATA_W - 1;

    reg_sel_e            sel;
    logic [2:0]          slot_idx;
    logic [NUM_SLOT-1:0] arm_q, mask_q, mask_d, pend;
    logic [NUM_SLOT-1:0] wr_hit, rd_hit, clr_hit;
    logic [DATA_W-1:0]   msg [NUM_SLOT];

    msg_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel (bus_sel),
        .bus_addr(bus_addr),
        .sel     (sel),
        .slot_idx(slot_idx)
    );

    assign mask_d = (sel == SEL_MASK && bus_wr) ? bus_wdata[NUM_SLOT-1:0] : mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q  <= '0;
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
            for (int k = 0; k < GROUP_SZ; k++) begin
                if (sel == SEL_ENA && bus_wr) arm_q[k]          <= bus_wdata[TOP_BIT-k];
                if (sel == SEL_ENB && bus_wr) arm_q[GROUP_SZ+k] <= bus_wdata[TOP_BIT-k];
            end
        end
    end

    for (genvar n = 0; n < NUM_SLOT; n++) begin : g_slot
        assign wr_hit[n]  = (sel == SEL_MSG) && bus_wr && (slot_idx == 3'(n));
        assign rd_hit[n]  = (sel == SEL_MSG) && !bus_wr && (slot_idx == 3'(n));
        assign clr_hit[n] = (sel == SEL_STAT) && bus_wr && bus_wdata[n];

        msg_slot #(.DATA_W(DATA_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit[n]),
            .rd_hit  (rd_hit[n]),
            .clr_hit (clr_hit[n]),
            .armed   (arm_q[n]),
            .mask_nxt(mask_d[n]),
            .wdata   (bus_wdata),
            .msg     (msg[n]),
            .pend    (pend[n]),
            .irq     (irq[n])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_wr) begin
            unique case (sel)
                SEL_MSG:  bus_rdata = msg[slot_idx];
                SEL_ENA:  for (int k = 0; k < GROUP_SZ; k++) bus_rdata[TOP_BIT-k] = arm_q[k];
                SEL_ENB:  for (int k = 0; k < GROUP_SZ; k++) bus_rdata[TOP_BIT-k] = arm_q[GROUP_SZ+k];
                SEL_STAT: bus_rdata[NUM_SLOT-1:0] = pend;
                SEL_MASK: bus_rdata[NUM_SLOT-1:0] = mask_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    p_stat_read_no_effect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_STAT && !bus_wr) |=> pend == $past(pend));
    p_mask_hides_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & mask_q) == '0);
endmodule

// File: tb/sim_msg_doorbell_unit.sv
module sim_msg_doorbell_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    msg_doorbell_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // {is_read, req, addr, wdata, expected rdata, expected irq after the op}
    localparam int NV = 21;
    localparam logic [84:0] VEC [NV] = '{
        {1'b1, 4'd8, 8'h28, 32'h0,        32'h0,        8'h00}, // R8 status clear after reset
        {1'b0, 4'd5, 8'h00, 32'h0000_00A5, 32'h0,       8'h00}, // R5 disarmed write
        {1'b1, 4'd5, 8'h28, 32'h0,        32'h0,        8'h00}, // R5 nothing pending
        {1'b0, 4'd7, 8'h20, 32'h8000_0000, 32'h0,       8'h00}, // R7 arm slot 0 (bit 31)
        {1'b1, 4'd5, 8'h28, 32'h0,        32'h0,        8'h00}, // R5 late arming recovers nothing
        {1'b1, 4'd7, 8'h20, 32'h0,        32'h8000_0000, 8'h00}, // R7 readback A
        {1'b1, 4'd1, 8'h00, 32'h0,        32'h0000_00A5, 8'h00}, // R1 data stored, read of idle slot
        {1'b0, 4'd2, 8'h00, 32'h0000_1111, 32'h0,       8'h01}, // R2 armed write raises irq0
        {1'b1, 4'd4, 8'h28, 32'h0,        32'h0000_0001, 8'h01}, // R4 status read, no side effect
        {1'b1, 4'd3, 8'h00, 32'h0,        32'h0000_1111, 8'h00}, // R3 read retires
        {1'b0, 4'd7, 8'h20, 32'hF000_0000, 32'h0,       8'h00}, // R7 arm slots 0..3
        {1'b0, 4'd7, 8'h24, 32'h1000_0000, 32'h0,       8'h00}, // R7 arm slot 7 (bit 28 of B)
        {1'b1, 4'd7, 8'h24, 32'h0,        32'h1000_0000, 8'h00}, // R7 readback B
        {1'b0, 4'd2, 8'h1C, 32'h0000_0077, 32'h0,       8'h80}, // R2 slot 7
        {1'b0, 4'd2, 8'h08, 32'h0000_0022, 32'h0,       8'h84}, // R2 slot 2
        {1'b0, 4'd4, 8'h28, 32'h0,        32'h0,        8'h84}, // R4 zeros have no effect
        {1'b0, 4'd4, 8'h28, 32'h0000_0004, 32'h0,       8'h80}, // R4 W1C slot 2
        {1'b0, 4'd6, 8'h2C, 32'h0000_0080, 32'h0,       8'h00}, // R6 mask slot 7
        {1'b1, 4'd6, 8'h28, 32'h0,        32'h0000_0080, 8'h00}, // R6 still pending
        {1'b0, 4'd6, 8'h2C, 32'h0,        32'h0,        8'h80}, // R6 unmask exposes
        {1'b1, 4'd1, 8'h1C, 32'h0,        32'h0000_0077, 8'h00}  // R1 slot 7 data, R3 retire
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit rd, input int req, input logic [7:0] a, input logic [31:0] d,
                          input logic [31:0] exp_rd, input logic [7:0] exp_irq);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = !rd; bus_addr = a; bus_wdata = d;
        #1;
        if (rd) check(req, bus_rdata, exp_rd, "rdata");
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check(req, {24'h0, irq}, {24'h0, exp_irq}, "irq");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(8, {24'h0, irq}, 32'h0, "irq in reset"); // R8
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][84], int'(VEC[i][83:80]), VEC[i][79:72], VEC[i][71:40],
                   VEC[i][39:8], VEC[i][7:0]);
        end
        // R2 a write to a pending slot keeps it pending; R3 one read retires it
        access(1'b0, 2, 8'h04, 32'h5, 32'h0, 8'h02);
        access(1'b0, 2, 8'h04, 32'h6, 32'h0, 8'h02);
        access(1'b1, 3, 8'h04, 32'h0, 32'h6, 8'h00);
        // R8 reset clears pending event, data and arm bits
        access(1'b0, 2, 8'h0C, 32'h33, 32'h0, 8'h08);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(8, {24'h0, irq}, 32'h0, "irq after reset");
        access(1'b1, 8, 8'h0C, 32'h0, 32'h0, 8'h00);
        access(1'b1, 8, 8'h20, 32'h0, 32'h0, 8'h00);
        access(1'b1, 8, 8'h28, 32'h0, 32'h0, 8'h00);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL R8 watchdog: actual hung expected done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule